// File: doc/BRIEF.md
# SPI-Addressed 8-bit GPIO Expander

This block is an SPI slave that gives a host control of eight general-purpose pins through a small file of 8-bit registers. A host selects the block with chip select and sends a control byte, then a register address byte. On a write, data bytes follow. On a read, the block shifts register contents back on MISO. The control byte holds a fixed device code, two address bits and a read/write flag, so up to four expanders can share one chip select. Each one takes only the frames that carry its own strap address.

The register file holds a per-pin direction mask, an input inversion mask, pull-up enables, a configuration byte, an output latch, and a port view that returns the live pin levels. Three interrupt-setup registers are stored and read back, but they drive no output. In sequential mode the register pointer steps after every data byte, so a single frame can move a run of registers. With sequential mode off, every data byte in the frame uses the same register. The SPI inputs are resampled on the system clock.

Top module: `spi_gpio_expander`

## Requirements
- R1: After reset every pin is an input (`pinOe` = 0x00), `pinOut` = 0x00, and the direction register at 0x00 reads back 0xFF.
- R2: The control byte is 0x40 | (device address << 1) | rw, where bit 0 set to 1 means read and 0 means write. The top five bits must equal 01000.
- R3: The block ignores any frame whose code or address bits do not match: no register changes and MISO stays 0. When bit 3 of the configuration register (0x05) is 0, the device address is 0 whatever the straps. When that bit is 1, the device address equals `strapAddr`.
- R4: A write frame (control, address, data) stores the data in the addressed register. A direction bit of 1 makes the pin an input and 0 makes it an output, so `pinOe` is the inverse of register 0x00. `pinOut` equals the output latch at 0x0A.
- R5: A read frame returns the addressed register on MISO, MSB first, in SPI mode 0, starting with the byte after the address byte.
- R6: Reading the port register 0x09 returns the input pins XORed with the polarity register at 0x01.
- R7: Writing the port register 0x09 updates the output latch at 0x0A.
- R8: When bit 5 of 0x05 is 0, the pointer advances after each data byte and wraps from 0x0A to 0x00. When that bit is 1, every data byte in the frame accesses the same register.
- R9: Addresses above 0x0A, the interrupt flag at 0x07 and the interrupt capture at 0x08 all read as zero and ignore writes.
- R10: Raising chip select ends the frame at once. A partly shifted byte is discarded, and the next frame starts again with a control byte.
- R11: The polarity (0x01), interrupt enable (0x02), default value (0x03), interrupt control (0x04), configuration (0x05) and pull-up (0x06) registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI lines |
| rstN | input | 1 | Active-low synchronous reset |
| sck | input | 1 | SPI serial clock, idle low |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host; 0 when not addressed for a read |
| strapAddr | input | 2 | Board-strapped device address |
| pinIn | input | 8 | Levels seen on the I/O pins |
| pinOut | output | 8 | Output latch value driven onto the pins |
| pinOe | output | 8 | Per-pin output enable (1 = drive) |

## Verification
Each register is tried with several distinct byte patterns, so a stuck or swapped bit gives a wrong readback. The port read is done with the polarity mask set to zero, to all ones and to a split value, which separates raw pins, full inversion and per-bit inversion. Frames are sent to the matching address, to the other address and with a wrong device code, both with address straps disabled and with them enabled. This shows whether the decode uses the straps or the fixed zero address. Burst frames with sequential mode on and off, one starting at the last register, and one frame cut off mid-byte separate stepping, wrap-around, holding and aborting.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_REGS  = 11;
  localparam int LAST_REG  = NUM_REGS - 1;
  localparam int IDX_W     = $clog2(NUM_REGS);

  localparam int A_DIR  = 0;
  localparam int A_POL  = 1;
  localparam int A_CFG  = 5;
  localparam int A_FLAG = 7;
  localparam int A_CAP  = 8;
  localparam int A_PORT = 9;
  localparam int A_LAT  = 10;

  localparam int CFG_SEQ_OFF = 5;
  localparam int CFG_HW_ADDR = 3;

  localparam logic [4:0] DEV_CODE = 5'b01000;

  typedef struct packed {
    logic              ldPtr;
    logic              wrEn;
    logic              incPtr;
    logic [DATA_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/gx_ctrl.sv
module gx_ctrl
  import gx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  input  logic [1:0]        strap,
  input  logic              hwAddrEn,
  input  logic [DATA_W-1:0] rdData,
  output logic              miso,
  output strobe_t           stb
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [SYNC_STAGES:0]   sckSh;
  logic [SYNC_STAGES-1:0] csSh;
  logic [SYNC_STAGES-1:0] mosiSh;

  logic              csAct, sckRise, sckFall, mosiBit, byteDone, ctlMatch;
  logic [BIT_W-1:0]  bitCnt;
  logic [1:0]        byteCnt;
  logic [DATA_W-2:0] rxShift;
  logic [DATA_W-1:0] rxByte, txShift;
  logic [1:0]        myAddr;
  logic              selected, isRead, loadPend;

  always_comb begin
    csAct    = ~csSh[SYNC_STAGES-1];
    sckRise  = sckSh[SYNC_STAGES-1] & ~sckSh[SYNC_STAGES];
    sckFall  = ~sckSh[SYNC_STAGES-1] & sckSh[SYNC_STAGES];
    mosiBit  = mosiSh[SYNC_STAGES-1];
    byteDone = csAct && sckRise && (bitCnt == BIT_W'(DATA_W-1));
    rxByte   = {rxShift, mosiBit};
    myAddr   = hwAddrEn ? strap : 2'b00;
    ctlMatch = (rxByte[7:3] == DEV_CODE) && (rxByte[2:1] == myAddr);
    stb      = '0;
    stb.data = rxByte;
    if (byteDone && selected) begin
      if (byteCnt == 2'd1) stb.ldPtr = 1'b1;
      else if (byteCnt == 2'd2) begin
        stb.wrEn   = ~isRead;
        stb.incPtr = 1'b1;
      end
    end
    miso = (selected && isRead) ? txShift[DATA_W-1] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSh    <= '0;
      csSh     <= '1;
      mosiSh   <= '0;
      bitCnt   <= '0;
      byteCnt  <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      selected <= 1'b0;
      isRead   <= 1'b0;
      loadPend <= 1'b0;
    end else begin
      sckSh    <= {sckSh[SYNC_STAGES-1:0], sck};
      csSh     <= {csSh[SYNC_STAGES-2:0], csN};
      mosiSh   <= {mosiSh[SYNC_STAGES-2:0], mosi};
      loadPend <= 1'b0;
      if (!csAct) begin
        bitCnt   <= '0;
        byteCnt  <= '0;
        txShift  <= '0;
        selected <= 1'b0;
        isRead   <= 1'b0;
      end else begin
        if (sckRise) begin
          rxShift <= rxByte[DATA_W-2:0];
          bitCnt  <= bitCnt + 1'b1;
        end
        if (sckFall && bitCnt != '0) txShift <= {txShift[DATA_W-2:0], 1'b0};
        if (byteDone) begin
          if (byteCnt != 2'd2) byteCnt <= byteCnt + 1'b1;
          if (byteCnt == 2'd0) begin
            selected <= ctlMatch;
            isRead   <= rxByte[0];
          end
          if (selected && isRead && byteCnt != 2'd0) loadPend <= 1'b1;
        end
        if (loadPend) txShift <= rdData;
      end
    end
  end

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !csAct |-> !(stb.ldPtr || stb.wrEn || stb.incPtr)); // R10
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !csAct |=> (bitCnt == '0) && !selected); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldPtr, stb.wrEn})); // R4
  AST_FOREIGN_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && byteCnt == 2'd0 && !ctlMatch) |=> !selected); // R3
endmodule

// File: rtl/gx_regs.sv
module gx_regs
  import gx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic              hwAddrEn,
  output logic              seqOff
);
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] ptr;
  logic              inRange;
  logic [IDX_W-1:0]  wrTgt;

  always_comb begin
    inRange = (ptr <= DATA_W'(LAST_REG));
    wrTgt   = (ptr == DATA_W'(A_PORT)) ? IDX_W'(A_LAT) : ptr[IDX_W-1:0];
    if (!inRange)                    rdData = '0;
    else if (ptr == DATA_W'(A_PORT)) rdData = pinIn ^ regFile[A_POL];
    else                             rdData = regFile[ptr[IDX_W-1:0]];
    pinOut   = regFile[A_LAT];
    pinOe    = ~regFile[A_DIR];
    hwAddrEn = regFile[A_CFG][CFG_HW_ADDR];
    seqOff   = regFile[A_CFG][CFG_SEQ_OFF];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == A_FLAG || i == A_CAP || i == A_PORT) begin : g_none
      assign regFile[i] = '0;
    end else begin : g_store
      localparam logic [DATA_W-1:0] RST_VAL = (i == A_DIR) ? '1 : '0;
      always_ff @(posedge clk) begin
        if (!rstN) regFile[i] <= RST_VAL;
        else if (stb.wrEn && inRange && wrTgt == IDX_W'(i)) regFile[i] <= stb.data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (stb.ldPtr) ptr <= stb.data;
    else if (stb.incPtr && !seqOff)
      ptr <= (ptr == DATA_W'(LAST_REG)) ? '0 : ptr + 1'b1;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incPtr && !seqOff && ptr == DATA_W'(LAST_REG)) |=> ptr == '0); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incPtr && seqOff && !stb.ldPtr) |=> $stable(ptr)); // R8
  AST_PORT_TO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && ptr == DATA_W'(A_PORT)) |=> pinOut == $past(stb.data)); // R7
  AST_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && ptr > DATA_W'(LAST_REG)) |=> $stable(pinOut) && $stable(pinOe) && $stable(seqOff)); // R9
endmodule

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander
  import gx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  logic [1:0]        strapAddr,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe
);
  strobe_t           stb;
  logic [DATA_W-1:0] rdData;
  logic              hwAddrEn, seqOff;

  gx_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi),
    .strap(strapAddr), .hwAddrEn(hwAddrEn), .rdData(rdData),
    .miso(miso), .stb(stb)
  );

  gx_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .pinIn(pinIn), .rdData(rdData),
    .pinOut(pinOut), .pinOe(pinOe), .hwAddrEn(hwAddrEn), .seqOff(seqOff)
  );

  AST_RESET_INPUTS: assert property (@(posedge clk)
    $rose(rstN) |-> pinOe == '0 && pinOut == '0); // R1
endmodule

// File: tb/spi_gpio_expander_tb.sv
module spi_gpio_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_CYC   = 8;

  logic       clk = 1'b0, rstN = 1'b0, sck = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic [1:0] strapAddr = 2'b01;
  logic [7:0] pinIn = 8'h00;
  logic       miso;
  logic [7:0] pinOut, pinOe;
  int errCnt = 0, chkCnt = 0;
  logic [7:0] wrCtl = 8'h40, rdCtl = 8'h41;

  spi_gpio_expander u_dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .strapAddr(strapAddr), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      waitClk(HALF_CYC);
      rx[b] = miso;
      sck = 1'b1;
      waitClk(HALF_CYC);
      sck = 1'b0;
    end
  endtask

  task automatic csLow();  csN = 1'b0; waitClk(HALF_CYC); endtask
  task automatic csHigh(); waitClk(HALF_CYC); csN = 1'b1; waitClk(HALF_CYC); endtask

  task automatic wrReg(input logic [7:0] ctl, input logic [7:0] adr, input logic [7:0] dat);
    logic [7:0] rx;
    csLow(); xferByte(ctl, rx); xferByte(adr, rx); xferByte(dat, rx); csHigh();
  endtask

  task automatic rdReg(input logic [7:0] ctl, input logic [7:0] adr, output logic [7:0] dat);
    logic [7:0] rx;
    csLow(); xferByte(ctl, rx); xferByte(adr, rx); xferByte(8'h00, dat); csHigh();
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 pinOe after reset", pinOe, 8'h00);
    check("R1 pinOut after reset", pinOut, 8'h00);
    rdReg(rdCtl, 8'h00, v);
    check("R1 R2 R5 direction reset readback", v, 8'hFF);
  endtask

  task automatic testPins();
    logic [7:0] v;
    wrReg(wrCtl, 8'h00, 8'hF0);
    check("R4 pinOe from direction", pinOe, 8'h0F);
    wrReg(wrCtl, 8'h0A, 8'hA5);
    check("R4 pinOut from latch", pinOut, 8'hA5);
    wrReg(wrCtl, 8'h09, 8'h3C);
    check("R7 port write drives latch", pinOut, 8'h3C);
    rdReg(rdCtl, 8'h0A, v);
    check("R7 latch readback", v, 8'h3C);
  endtask

  task automatic testPolarity();
    logic [7:0] v;
    pinIn = 8'h96;
    rdReg(rdCtl, 8'h09, v);
    check("R6 port raw", v, 8'h96);
    wrReg(wrCtl, 8'h01, 8'hFF);
    rdReg(rdCtl, 8'h09, v);
    check("R6 port inverted", v, 8'h69);
    wrReg(wrCtl, 8'h01, 8'h0F);
    rdReg(rdCtl, 8'h09, v);
    check("R6 port split inversion", v, 8'h99);
    rdReg(rdCtl, 8'h01, v);
    check("R11 polarity readback", v, 8'h0F);
  endtask

  task automatic testAddress();
    logic [7:0] v;
    wrReg(wrCtl, 8'h06, 8'h5A);
    wrReg(8'h42, 8'h06, 8'h11);
    rdReg(rdCtl, 8'h06, v);
    check("R3 strap ignored while disabled", v, 8'h5A);
    rdReg(8'h43, 8'h06, v);
    check("R3 foreign read leaves miso low", v, 8'h00);
    wrReg(8'h50, 8'h06, 8'h22);
    rdReg(rdCtl, 8'h06, v);
    check("R2 R3 bad device code ignored", v, 8'h5A);
    wrReg(wrCtl, 8'h05, 8'h08);
    wrCtl = 8'h42; rdCtl = 8'h43;
    wrReg(8'h40, 8'h06, 8'h33);
    rdReg(rdCtl, 8'h06, v);
    check("R3 address 0 ignored when straps on", v, 8'h5A);
    rdReg(8'h41, 8'h06, v);
    check("R3 address 0 read quiet when straps on", v, 8'h00);
    wrReg(wrCtl, 8'h06, 8'hC3);
    rdReg(rdCtl, 8'h06, v);
    check("R3 R11 strap address write", v, 8'hC3);
    rdReg(rdCtl, 8'h05, v);
    check("R11 config readback", v, 8'h08);
    wrReg(wrCtl, 8'h05, 8'h00);
    wrCtl = 8'h40; rdCtl = 8'h41;
    rdReg(rdCtl, 8'h06, v);
    check("R3 back to address 0", v, 8'hC3);
  endtask

  task automatic testSequential();
    logic [7:0] rx, a, b, c;
    csLow(); xferByte(wrCtl, rx); xferByte(8'h02, rx);
    xferByte(8'h11, rx); xferByte(8'h22, rx); xferByte(8'h33, rx); csHigh();
    rdReg(rdCtl, 8'h02, a); check("R8 R11 burst reg 0x02", a, 8'h11);
    rdReg(rdCtl, 8'h03, a); check("R8 R11 burst reg 0x03", a, 8'h22);
    rdReg(rdCtl, 8'h04, a); check("R8 R11 burst reg 0x04", a, 8'h33);
    csLow(); xferByte(rdCtl, rx); xferByte(8'h02, rx);
    xferByte(8'h00, a); xferByte(8'h00, b); xferByte(8'h00, c); csHigh();
    check("R8 burst read 1", a, 8'h11);
    check("R8 burst read 2", b, 8'h22);
    check("R8 burst read 3", c, 8'h33);
    csLow(); xferByte(wrCtl, rx); xferByte(8'h0A, rx);
    xferByte(8'h77, rx); xferByte(8'hEE, rx); csHigh();
    check("R8 wrap latch", pinOut, 8'h77);
    check("R8 wrap to direction", pinOe, 8'h11);
    csLow(); xferByte(rdCtl, rx); xferByte(8'h0A, rx);
    xferByte(8'h00, a); xferByte(8'h00, b); csHigh();
    check("R8 wrap read latch", a, 8'h77);
    check("R8 wrap read direction", b, 8'hEE);
    wrReg(wrCtl, 8'h05, 8'h20);
    csLow(); xferByte(wrCtl, rx); xferByte(8'h02, rx);
    xferByte(8'hAA, rx); xferByte(8'hBB, rx); csHigh();
    rdReg(rdCtl, 8'h02, a); check("R8 hold last write", a, 8'hBB);
    rdReg(rdCtl, 8'h03, a); check("R8 hold neighbour untouched", a, 8'h22);
    csLow(); xferByte(rdCtl, rx); xferByte(8'h03, rx);
    xferByte(8'h00, a); xferByte(8'h00, b); csHigh();
    check("R8 hold read 1", a, 8'h22);
    check("R8 hold read 2", b, 8'h22);
    wrReg(wrCtl, 8'h05, 8'h00);
  endtask

  task automatic testHighAddr();
    logic [7:0] v;
    wrReg(wrCtl, 8'h0C, 8'h55);
    rdReg(rdCtl, 8'h0C, v);
    check("R9 above map reads zero", v, 8'h00);
    check("R9 above map leaves latch", pinOut, 8'h77);
    wrReg(wrCtl, 8'h07, 8'hFF);
    rdReg(rdCtl, 8'h07, v);
    check("R9 flag reads zero", v, 8'h00);
    wrReg(wrCtl, 8'h08, 8'hFF);
    rdReg(rdCtl, 8'h08, v);
    check("R9 capture reads zero", v, 8'h00);
  endtask

  task automatic testAbort();
    logic [7:0] rx, v;
    csLow(); xferByte(wrCtl, rx); xferByte(8'h06, rx);
    for (int b = 7; b >= 4; b--) begin
      mosi = 1'b0;
      waitClk(HALF_CYC); sck = 1'b1; waitClk(HALF_CYC); sck = 1'b0;
    end
    csHigh();
    rdReg(rdCtl, 8'h06, v);
    check("R10 aborted byte discarded", v, 8'hC3);
    wrReg(wrCtl, 8'h06, 8'h81);
    rdReg(rdCtl, 8'h06, v);
    check("R10 next frame clean", v, 8'h81);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testPins();
    testPolarity();
    testAddress();
    testSequential();
    testHighAddr();
    testAbort();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule